// File: doc/BRIEF.md
# Low-Power Coprocessor Execution Core

A small sequential core for an always-on domain. It runs short programs that sit in a shared, word-addressed memory. Software writes a program into memory and pulses `start_i` with the first instruction's word address. The core then fetches and executes one 32-bit instruction at a time until it meets a halt. At the halt it pulses `done_o` and returns to idle.

The core holds four 16-bit general registers (R0..R3), an 8-bit stage counter, and zero and overflow flags left by the last ALU operation. It supports the following instruction groups:

- loads;
- stores, where each stored word is tagged with the PC and the index of the address register;
- register and immediate ALU operations;
- absolute branches, conditional on the flags;
- relative branches that compare R0 or the stage counter against an immediate;
- stage-counter updates;
- halt.

Every other opcode executes as a no-op. All addresses and PC values count 32-bit words.

The single memory port has a one-cycle read latency: read data is presented on the cycle after the request. Writes take effect at the clock edge where the request is made.

Top module: `lpc_core`

## Requirements
- R1: After reset `halted_o`=1, `done_o`=0 and `mem_req_o`=0. While the core is halted, a `start_i` pulse loads the PC from `start_addr_i`, and `halted_o` falls at the next edge.
- R2: Timing, counted from the edge that samples `start_i`:
  - the first instruction executes at the 2nd edge after it;
  - each instruction takes 2 cycles, and a load takes 3;
  - so the halt that is the n-th executed instruction, with k loads before it, raises `done_o` after edge 2n+k.
- R3: The opcode is bits [31:28]. ALU is opcode 0x7:
  - sub-opcode [27:25]: 0 = register form, 1 = immediate form;
  - select [24:21]: 0 add, 1 sub, 2 and, 3 or, 4 move B, 5 shift left, 6 shift right;
  - destination rd [1:0], operand A rs [3:2];
  - operand B is rt [5:4] in the register form, or the 16-bit immediate [19:4] in the immediate form.
- R4: Each ALU operation sets the zero flag when its 16-bit result is 0. It sets the overflow flag to the carry-out for add and to the borrow for subtract. Every other ALU operation clears the overflow flag.
- R5: Store is opcode 0x6:
  - value register [1:0], address register [3:2], offset [20:10];
  - it writes `{PC[10:0], 3'b000, address-register index, value}` to address (address register + offset).
- R6: Load is opcode 0xD, with destination [1:0], address register [3:2] and offset [20:10]. It puts the low 16 bits of the word at (address register + offset) into the destination register.
- R7: Absolute branch is opcode 0x8 with sub-opcode 0:
  - condition [17:16]: 0 always, 1 zero flag set, 2 overflow flag set;
  - [15] = 1 takes the target from register [1:0], otherwise from the immediate [14:4].
- R8: R0 branch is opcode 0x8 with sub-opcode 1. Bit [16] selects the compare: 0 means R0 < imm[15:0], 1 means R0 >= imm. When the compare holds, the PC moves by a magnitude [23:17], backwards when bit [24] is set.
- R9: Stage operations are opcode 0x7 with sub-opcode 2. Select 0 adds imm[11:4], 1 subtracts it, 2 clears the counter. The 8-bit counter wraps, and these operations leave the flags unchanged.
- R10: Stage branch is opcode 0x8 with sub-opcode 2. It compares the counter with imm[7:0] using [9:8]: 0 means <, 1 means >=, 2 means <=. Offset and sign are laid out as in R8.
- R11: Halt (opcode 0xB) returns the core to idle. `done_o` is high for exactly one cycle, and no memory request is made while the core is halted.
- R12: Any other opcode, or an ALU select above 6, changes no register, flag or memory, and execution moves on to PC+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, honoured while halted |
| start_addr_i | input | AW | Word address of the first instruction |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write enable for the request |
| mem_addr_o | output | AW | Word address |
| mem_wdata_o | output | 32 | Store data |
| mem_rdata_i | input | 32 | Read data, one cycle after a read request |
| halted_o | output | 1 | Core idle |
| done_o | output | 1 | One-cycle pulse when a halt executes |

## Verification
A fetch drives a read at the edge after the PC is set. The instruction is executed at the following edge, and a store appears on the port during that execute cycle, so the monitor samples it at the falling edge inside that cycle. The bench counts rising edges from the edge that captures `start_i` to the first falling edge with `done_o` high. It compares that count against 2n+k, worked out from the path each program takes, and checks one edge later that the pulse has ended. Register contents and flag effects are only visible through tagged stores. These reach a scoreboard in program order, and the scoreboard must be empty when each program ends.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
  localparam logic [3:0] OP_ST   = 4'h6;
  localparam logic [3:0] OP_ALU  = 4'h7;
  localparam logic [3:0] OP_BR   = 4'h8;
  localparam logic [3:0] OP_HALT = 4'hB;
  localparam logic [3:0] OP_LD   = 4'hD;

  localparam logic [2:0] SUB_REG = 3'd0;
  localparam logic [2:0] SUB_IMM = 3'd1;
  localparam logic [2:0] SUB_STG = 3'd2;

  localparam logic [2:0] BR_ABS = 3'd0;
  localparam logic [2:0] BR_R0  = 3'd1;
  localparam logic [2:0] BR_STG = 3'd2;

  localparam logic [3:0] SEL_ADD = 4'd0;
  localparam logic [3:0] SEL_SUB = 4'd1;
  localparam logic [3:0] SEL_AND = 4'd2;
  localparam logic [3:0] SEL_OR  = 4'd3;
  localparam logic [3:0] SEL_MOV = 4'd4;
  localparam logic [3:0] SEL_LSH = 4'd5;
  localparam logic [3:0] SEL_RSH = 4'd6;

  localparam logic [1:0] STG_INC = 2'd0;
  localparam logic [1:0] STG_DEC = 2'd1;
  localparam logic [1:0] STG_RST = 2'd2;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_EXEC, ST_LDWB} core_state_e;
endpackage

// File: rtl/lpc_regfile.sv
module lpc_regfile #(
  parameter int NREG = 4,
  parameter int DW   = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] regs_o [NREG]
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                regs_o[g] <= '0;
      else if (we_i && (waddr_i == IW'(g)))       regs_o[g] <= wdata_i;
    end
  end
endmodule

// File: rtl/lpc_alu.sv
module lpc_alu
  import lpc_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [3:0]    sel_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] res_o,
  output logic          zero_o,
  output logic          ovf_o,
  output logic          ok_o
);
  logic [DW:0] sum, diff;

  always_comb begin
    sum   = {1'b0, a_i} + {1'b0, b_i};
    diff  = {1'b0, a_i} - {1'b0, b_i};
    res_o = '0;
    ovf_o = 1'b0;
    ok_o  = 1'b1;
    unique case (sel_i)
      SEL_ADD: begin res_o = sum[DW-1:0];  ovf_o = sum[DW];  end
      SEL_SUB: begin res_o = diff[DW-1:0]; ovf_o = diff[DW]; end
      SEL_AND: res_o = a_i & b_i;
      SEL_OR:  res_o = a_i | b_i;
      SEL_MOV: res_o = b_i;
      SEL_LSH: res_o = a_i << b_i;
      SEL_RSH: res_o = a_i >> b_i;
      default: ok_o = 1'b0;
    endcase
    zero_o = (res_o == '0);
  end
endmodule

// File: rtl/lpc_stage.sv
module lpc_stage
  import lpc_pkg::*;
#(
  parameter int SW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [1:0]    op_i,
  input  logic [SW-1:0] imm_i,
  output logic [SW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else if (en_i) begin
      unique case (op_i)
        STG_INC: cnt_o <= cnt_o + imm_i;
        STG_DEC: cnt_o <= cnt_o - imm_i;
        STG_RST: cnt_o <= '0;
        default: cnt_o <= cnt_o;
      endcase
    end
  end

  assert_stage_wrap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i == STG_INC && cnt_o == '1 && imm_i == SW'(1)) |=> (cnt_o == '0));
  assert_stage_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i == STG_RST) |=> (cnt_o == '0));
endmodule

// File: rtl/lpc_branch.sv
module lpc_branch
  import lpc_pkg::*;
#(
  parameter int AW  = 11,
  parameter int DW  = 16,
  parameter int SW  = 8,
  parameter int MW  = 7
) (
  input  logic [2:0]    kind_i,
  input  logic [AW-1:0] pc_i,
  input  logic [1:0]    cond_i,
  input  logic          use_reg_i,
  input  logic [AW-1:0] tgt_imm_i,
  input  logic [AW-1:0] tgt_reg_i,
  input  logic          sign_i,
  input  logic [MW-1:0] mag_i,
  input  logic          ge_i,
  input  logic [DW-1:0] imm16_i,
  input  logic [DW-1:0] r0_i,
  input  logic [1:0]    scmp_i,
  input  logic [SW-1:0] simm_i,
  input  logic [SW-1:0] stage_i,
  input  logic          zf_i,
  input  logic          of_i,
  output logic          taken_o,
  output logic [AW-1:0] target_o
);
  logic [AW-1:0] rel_tgt;

  always_comb begin
    rel_tgt  = sign_i ? (pc_i - AW'(mag_i)) : (pc_i + AW'(mag_i));
    taken_o  = 1'b0;
    target_o = rel_tgt;
    unique case (kind_i)
      BR_ABS: begin
        target_o = use_reg_i ? tgt_reg_i : tgt_imm_i;
        unique case (cond_i)
          2'd0:    taken_o = 1'b1;
          2'd1:    taken_o = zf_i;
          2'd2:    taken_o = of_i;
          default: taken_o = 1'b0;
        endcase
      end
      BR_R0:  taken_o = ge_i ? (r0_i >= imm16_i) : (r0_i < imm16_i);
      BR_STG: begin
        unique case (scmp_i)
          2'd0:    taken_o = stage_i <  simm_i;
          2'd1:    taken_o = stage_i >= simm_i;
          2'd2:    taken_o = stage_i <= simm_i;
          default: taken_o = 1'b0;
        endcase
      end
      default: taken_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/lpc_core.sv
module lpc_core
  import lpc_pkg::*;
#(
  parameter int AW   = 11,
  parameter int DW   = 16,
  parameter int SW   = 8,
  parameter int NREG = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic [31:0]   mem_rdata_i,
  output logic          halted_o,
  output logic          done_o
);
  localparam int RIW   = $clog2(NREG);
  localparam int TAG_W = 32 - 3 - RIW - DW;
  localparam int OFF_W = 11;
  localparam int MAG_W = 7;

  core_state_e state_q;
  logic [AW-1:0] pc_q;
  logic [RIW-1:0] ld_rd_q;
  logic zf_q, of_q, done_q;

  logic [31:0] ins;
  logic [3:0]  op, sel;
  logic [2:0]  sub;
  logic [RIW-1:0] f_rd, f_rs, f_rt;
  logic exec, do_alu, do_stg, do_st, do_ld, do_br, do_halt;
  logic [DW-1:0] regs [NREG];
  logic [DW-1:0] opb, alu_res, rf_wdata;
  logic alu_zero, alu_ovf, alu_ok, rf_we;
  logic [RIW-1:0] rf_waddr;
  logic [SW-1:0] stage;
  logic br_taken;
  logic [AW-1:0] br_target, ea;

  assign ins  = mem_rdata_i;
  assign op   = ins[31:28];
  assign sub  = ins[27:25];
  assign sel  = ins[24:21];
  assign f_rd = ins[RIW-1:0];
  assign f_rs = ins[RIW+1:2];
  assign f_rt = ins[RIW+3:4];
  assign exec = (state_q == ST_EXEC);

  always_comb begin
    do_alu  = exec && op == OP_ALU && (sub == SUB_REG || sub == SUB_IMM);
    do_stg  = exec && op == OP_ALU && sub == SUB_STG;
    do_st   = exec && op == OP_ST;
    do_ld   = exec && op == OP_LD;
    do_br   = exec && op == OP_BR;
    do_halt = exec && op == OP_HALT;
    opb     = (sub == SUB_IMM) ? DW'(ins[19:4]) : regs[f_rt];
    ea      = AW'(regs[f_rs]) + AW'(ins[20:10]);
  end

  lpc_regfile #(.NREG(NREG), .DW(DW)) u_rf (
    .clk_i, .rst_ni, .we_i(rf_we), .waddr_i(rf_waddr), .wdata_i(rf_wdata), .regs_o(regs)
  );

  lpc_alu #(.DW(DW)) u_alu (
    .sel_i(sel), .a_i(regs[f_rs]), .b_i(opb),
    .res_o(alu_res), .zero_o(alu_zero), .ovf_o(alu_ovf), .ok_o(alu_ok)
  );

  lpc_stage #(.SW(SW)) u_stage (
    .clk_i, .rst_ni, .en_i(do_stg), .op_i(sel[1:0]), .imm_i(SW'(ins[11:4])), .cnt_o(stage)
  );

  lpc_branch #(.AW(AW), .DW(DW), .SW(SW), .MW(MAG_W)) u_br (
    .kind_i(sub), .pc_i(pc_q), .cond_i(ins[17:16]), .use_reg_i(ins[15]),
    .tgt_imm_i(AW'(ins[14:4])), .tgt_reg_i(AW'(regs[f_rd])),
    .sign_i(ins[24]), .mag_i(ins[23:17]), .ge_i(ins[16]), .imm16_i(DW'(ins[15:0])),
    .r0_i(regs[0]), .scmp_i(ins[9:8]), .simm_i(SW'(ins[7:0])), .stage_i(stage),
    .zf_i(zf_q), .of_i(of_q), .taken_o(br_taken), .target_o(br_target)
  );

  always_comb begin
    rf_we    = (do_alu && alu_ok) || (state_q == ST_LDWB);
    rf_waddr = (state_q == ST_LDWB) ? ld_rd_q : f_rd;
    rf_wdata = (state_q == ST_LDWB) ? mem_rdata_i[DW-1:0] : alu_res;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pc_q    <= '0;
      ld_rd_q <= '0;
      zf_q    <= 1'b0;
      of_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= do_halt;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          pc_q    <= start_addr_i;
          state_q <= ST_FETCH;
        end
        ST_FETCH: state_q <= ST_EXEC;
        ST_EXEC: begin
          if (do_alu && alu_ok) begin
            zf_q <= alu_zero;
            of_q <= alu_ovf;
          end
          if (do_halt) begin
            state_q <= ST_IDLE;
          end else if (do_ld) begin
            ld_rd_q <= f_rd;
            pc_q    <= pc_q + AW'(1);
            state_q <= ST_LDWB;
          end else begin
            pc_q    <= (do_br && br_taken) ? br_target : pc_q + AW'(1);
            state_q <= ST_FETCH;
          end
        end
        ST_LDWB: state_q <= ST_FETCH;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o   = (state_q == ST_FETCH) || do_ld || do_st;
  assign mem_we_o    = do_st;
  assign mem_addr_o  = (state_q == ST_FETCH) ? pc_q : ea;
  assign mem_wdata_o = {TAG_W'(pc_q), 3'b000, f_rs, regs[f_rd]};
  assign halted_o    = (state_q == ST_IDLE);
  assign done_o      = done_q;

  assert_fetch_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FETCH) |-> (mem_req_o && !mem_we_o && mem_addr_o == pc_q));
  assert_store_one_cycle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> (state_q == ST_FETCH && !mem_we_o));
  assert_done_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> halted_o);
  assert_idle_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> !mem_req_o);
  assert_shift_no_ovf_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_alu && (sel == SEL_LSH || sel == SEL_RSH)) |=> !of_q);
  assert_start_pc_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_o && start_i) |=> (!halted_o && pc_q == $past(start_addr_i)));
endmodule

// File: tb/lpc_core_tb_top.sv
module lpc_core_tb_top;
  logic clk = 1'b0;
  logic rst_n, start;
  logic [10:0] start_addr;
  logic mem_req, mem_we, halted, done;
  logic [10:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [31:0] mem [0:255];

  int n_chk = 0;
  int n_err = 0;

  typedef struct {
    logic [10:0] a;
    logic [31:0] d;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #10 clk = ~clk;

  lpc_core dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_addr_i(start_addr),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .halted_o(halted), .done_o(done)
  );

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      mem_rdata <= mem[mem_addr[7:0]];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    exp_t e;
    if (rst_n && mem_req && mem_we) begin
      if (sb_q.size() == 0) begin
        n_chk++; n_err++;
        $display("FAIL R5 unexpected store actual=%h@%0d expected=none", mem_wdata, mem_addr);
      end else begin
        e = sb_q.pop_front();
        chk({e.tag, " addr"}, 32'(mem_addr), 32'(e.a));
        chk({e.tag, " data"}, mem_wdata, e.d);
      end
    end
  end

  task automatic push(input int a, input int pc, input int ra, input int v, input string tag);
    exp_t e;
    e.a = 11'(a);
    e.d = (32'(pc) << 21) | (32'(ra) << 16) | (32'(v) & 32'hFFFF);
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  function automatic logic [31:0] alu_i(int sel, int rd, int rs, int imm);
    return (32'h7 << 28) | (32'd1 << 25) | (32'(sel) << 21) | ((32'(imm) & 32'hFFFF) << 4) | (32'(rs) << 2) | 32'(rd);
  endfunction
  function automatic logic [31:0] alu_r(int sel, int rd, int rs, int rt);
    return (32'h7 << 28) | (32'(sel) << 21) | (32'(rt) << 4) | (32'(rs) << 2) | 32'(rd);
  endfunction
  function automatic logic [31:0] stg(int sel, int imm);
    return (32'h7 << 28) | (32'd2 << 25) | (32'(sel) << 21) | (32'(imm) << 4);
  endfunction
  function automatic logic [31:0] st_w(int rv, int ra, int off);
    return (32'h6 << 28) | (32'(off) << 10) | (32'(ra) << 2) | 32'(rv);
  endfunction
  function automatic logic [31:0] ld_w(int rd, int ra, int off);
    return (32'hD << 28) | (32'(off) << 10) | (32'(ra) << 2) | 32'(rd);
  endfunction
  function automatic logic [31:0] bx(int cnd, int use_reg, int r, int tgt);
    return (32'h8 << 28) | (32'(cnd) << 16) | (32'(use_reg) << 15) | (32'(tgt) << 4) | 32'(r);
  endfunction
  function automatic logic [31:0] br0(int off, int ge, int imm);
    int m = (off < 0) ? -off : off;
    return (32'h8 << 28) | (32'd1 << 25) | (32'(off < 0) << 24) | (32'(m) << 17) | (32'(ge) << 16) | 32'(imm);
  endfunction
  function automatic logic [31:0] bs(int off, int cmp, int imm);
    int m = (off < 0) ? -off : off;
    return (32'h8 << 28) | (32'd2 << 25) | (32'(off < 0) << 24) | (32'(m) << 17) | (32'(cmp) << 8) | 32'(imm);
  endfunction
  localparam logic [31:0] HALT = 32'hB000_0000;

  task automatic run_prog(input int addr, input int exp_cyc, input string tag);
    int cnt = 0;
    bit got = 0;
    @(negedge clk); start = 1'b1; start_addr = 11'(addr);
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    chk({tag, " R1 halted low after start"}, 32'(halted), 32'd0);
    while (!got && cnt < 2000) begin
      @(posedge clk); cnt++;
      @(negedge clk); got = done;
    end
    if (!got) begin
      n_chk++; n_err++;
      $display("FAIL %s R11 watchdog actual=no-done expected=done", tag);
    end else begin
      chk({tag, " R2 cycles to done"}, 32'(cnt), 32'(exp_cyc));
      chk({tag, " R11 halted at done"}, 32'(halted), 32'd1);
      @(negedge clk);
      chk({tag, " R11 done one cycle"}, 32'(done), 32'd0);
    end
    chk({tag, " R5 scoreboard drained"}, 32'(sb_q.size()), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    // program A at 0: ALU, store tag, overflow branch, shift
    mem[0]  = alu_i(4, 3, 0, 100);
    mem[1]  = alu_i(4, 0, 0, 7);
    mem[2]  = alu_i(0, 1, 0, 5);
    mem[3]  = st_w(1, 3, 0);
    mem[4]  = alu_r(1, 2, 0, 1);
    mem[5]  = st_w(2, 3, 1);
    mem[6]  = bx(2, 0, 0, 9);
    mem[7]  = alu_i(4, 0, 0, 16'h55);
    mem[8]  = st_w(0, 3, 2);
    mem[9]  = alu_i(5, 0, 0, 2);
    mem[10] = st_w(0, 3, 3);
    mem[11] = HALT;
    // program B at 32: load, R0 loop, AND
    mem[32] = alu_i(4, 0, 0, 0);
    mem[33] = alu_i(4, 3, 0, 200);
    mem[34] = ld_w(1, 3, 0);
    mem[35] = alu_i(0, 3, 3, 1);
    mem[36] = st_w(0, 3, 0);
    mem[37] = alu_i(0, 0, 0, 1);
    mem[38] = br0(-3, 0, 3);
    mem[39] = alu_i(2, 2, 1, 16'h00FF);
    mem[40] = st_w(2, 3, 1);
    mem[41] = HALT;
    mem[200] = 32'h1234_ABCD;
    // program C at 64: stage counter, zero flag, register branch, BGE, unknown opcode
    mem[64] = stg(2, 0);
    mem[65] = stg(0, 5);
    mem[66] = stg(1, 2);
    mem[67] = bs(2, 2, 3);
    mem[68] = HALT;
    mem[69] = bs(2, 0, 3);
    mem[70] = alu_i(4, 1, 0, 150);
    mem[71] = alu_i(4, 0, 0, 16'hFFFF);
    mem[72] = alu_i(0, 0, 0, 1);
    mem[73] = bx(1, 0, 0, 75);
    mem[74] = HALT;
    mem[75] = st_w(0, 1, 0);
    mem[76] = alu_i(4, 2, 0, 80);
    mem[77] = bx(0, 1, 2, 0);
    mem[78] = HALT;
    mem[79] = HALT;
    mem[80] = stg(1, 4);
    mem[81] = bs(2, 1, 255);
    mem[82] = HALT;
    mem[83] = alu_i(4, 0, 0, 500);
    mem[84] = br0(2, 1, 500);
    mem[85] = HALT;
    mem[86] = st_w(0, 1, 1);
    mem[87] = 32'h3000_0000;
    mem[88] = st_w(0, 1, 2);
    mem[89] = HALT;

    rst_n = 1'b0; start = 1'b0; start_addr = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset halted", 32'(halted), 32'd1);
    chk("R1 reset done", 32'(done), 32'd0);
    chk("R1 reset req", 32'(mem_req), 32'd0);
    rst_n = 1'b1;

    push(100, 3, 3, 12, "R3 add imm / R5 tag");
    push(101, 5, 3, 16'hFFFB, "R3 sub reg");
    push(103, 10, 3, 28, "R7 ovf branch / R4 borrow / R3 lsh");
    run_prog(0, 20, "progA");
    chk("R7 skipped store left memory", mem[102], 32'h0);

    push(201, 36, 3, 0, "R8 loop iter0");
    push(202, 36, 3, 1, "R8 loop iter1");
    push(203, 36, 3, 2, "R8 loop iter2");
    push(204, 40, 3, 16'hCD, "R6 load low half / R3 and");
    run_prog(32, 37, "progB");

    push(150, 75, 1, 0, "R10 stage LE/LT / R4 carry zero / R7 zero branch");
    push(151, 86, 1, 500, "R9 stage wrap / R10 GE / R7 reg target / R8 GE");
    push(152, 88, 1, 500, "R12 unknown opcode no-op");
    run_prog(64, 40, "progC");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule